// File: doc/BRIEF.md
# Hidden special-register load scheduler

This block sits between a graphics memory controller's access sequencer and the pins of a synchronous graphics DRAM. It places loads of the device's color register and mask register into bus cycles that the access stream leaves unused. The access sequencer presents one command per cycle (idle, row open, read, write), its write data, and for each column command a per-beat mask of beats it does not need. A requester holds a load request with a select bit and a data word until it is acknowledged.

Each cycle the scheduler knows which future cycles will carry read data and which will carry write data. A load goes out in the first cycle where the sequencer offers an idle command and DQ is quiet. Such cycles include the activate-to-column delay, the CAS-latency gap after a read, and beats that the sequencer marked as unneeded. Unneeded read beats are masked two clocks ahead so the memory keeps its drivers off, and unneeded write beats are masked one clock ahead so the array keeps its old contents. If no such cycle turns up within a set number of cycles, the scheduler takes the command slot from the sequencer (stall) in the next cycle with quiet DQ.

Top module: `smr_hide_sched`

## Requirements
- R1: After reset, with no request and an idle command input, the block drives an idle command (code 0), no DQM, DQ output enable low, no acknowledge and no stall.
- R2: While no load is requested, the command and address outputs follow the access inputs unchanged, with codes idle=0, row open=1, read=2, write=3, and stall stays low.
- R3: A load cycle drives command code 4 and an address with bit 6 set and bit 5 clear for the color register (select 0), or bit 5 set and bit 6 clear for the mask register (select 1), all other bits zero, with the load word on DQ and the output enable high.
- R4: A held request is issued in the first cycle where the access command is idle and no needed read or write beat occupies DQ, and is acknowledged in that same cycle.
- R5: A request held across a row open command is issued in the following idle cycle of the activate-to-column delay.
- R6: With CAS latency 3, a request present when a read is issued goes out in the cycle after the read, before read data reaches the bus.
- R7: For a read issued in cycle c, an unneeded beat k (mask bit k set) raises DQM in cycle c+CL+k-2 and frees DQ in cycle c+CL+k; DQM stays low for needed beats.
- R8: For a write issued in cycle c, an unneeded beat k with k of at least 1 raises DQM in cycle c+k-1 and frees DQ in cycle c+k; beat 0 is always driven and never masked.
- R9: Needed write beats drive the sequencer's write data on DQ with the output enable high, and the output enable drops once the burst ends.
- R10: The output enable is never high in a cycle where the memory drives read data, that is, a read beat not masked two cycles earlier.
- R11: A request waiting TIMEOUT cycles with no hidden slot is forced in the next cycle with quiet DQ: stall goes high, the load replaces the sequencer's command, and the held command goes out in a later cycle.
- R12: The acknowledge is high for exactly the cycles that carry a load command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_cmd | input | 2 | Sequencer command: 0 idle, 1 row open, 2 read, 3 write |
| acc_addr | input | AW | Sequencer address |
| acc_wdata | input | DW | Write data for the write beat in the current cycle |
| acc_skip | input | BL | With a read or write, bit k marks beat k as not needed |
| ld_req | input | 1 | Load request, held until acknowledged |
| ld_sel | input | 1 | 0 selects the color register, 1 the mask register |
| ld_data | input | DW | Word to load |
| mem_cmd | output | 3 | Command to memory: access codes plus 4 for a register load |
| mem_addr | output | AW | Address, or the load opcode |
| mem_dq_out | output | DW | Data driven onto DQ |
| mem_dq_oe | output | 1 | DQ output enable |
| mem_dqm | output | 1 | Data mask to memory |
| ld_ack | output | 1 | One-cycle pulse in the cycle a load issues |
| acc_stall | output | 1 | Sequencer command not taken this cycle; hold it |

## Verification
The bench sweeps each single unneeded beat position of a read and of a write, plus the all-needed case. A mask placed one cycle off would either let the memory drive DQ while the load is on it, or block a needed beat, and an off-by-one slot choice shows up as an acknowledge in the wrong cycle. Write beat 0 is marked unneeded on purpose: a design that honoured that mark would drop data or try a load in a cycle whose command slot is taken. The timeout is tried with the bus quiet and with a read burst in flight. A forced load that ignored the burst would collide with read data, and a stall that lost the held command would drop a row open.

// File: rtl/smr_hide_sched.sv
module smr_hide_sched #(
  parameter int DW      = 16,
  parameter int AW      = 11,
  parameter int CL      = 3,
  parameter int BL      = 8,
  parameter int TIMEOUT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    acc_cmd,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_wdata,
  input  logic [BL-1:0] acc_skip,
  input  logic          ld_req,
  input  logic          ld_sel,
  input  logic [DW-1:0] ld_data,
  output logic [2:0]    mem_cmd,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  output logic          mem_dqm,
  output logic          ld_ack,
  output logic          acc_stall
);
  localparam int RW = CL + BL - 1;
  localparam int WW = BL - 1;
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [1:0] C_NOP = 2'd0;
  localparam logic [1:0] C_RD  = 2'd2;
  localparam logic [1:0] C_WR  = 2'd3;
  localparam logic [2:0] M_LOAD = 3'd4;

  logic [RW-1:0] rd_need_q, rd_skp_q, rd_need_n, rd_skp_n;
  logic [WW-1:0] wr_need_q, wr_skp_q, wr_need_n, wr_skp_n;
  logic [TW-1:0] wait_q;
  logic          busy, hide, force_ld, issue, rd_go, wr_go, wr_beat;
  logic [AW-1:0] opcode;

  assign busy     = rd_need_q[0] | wr_need_q[0];
  assign hide     = ld_req & (acc_cmd == C_NOP) & ~busy;
  assign force_ld = ld_req & ~hide & ~busy & (wait_q == TW'(TIMEOUT));
  assign issue    = hide | force_ld;
  assign rd_go    = (acc_cmd == C_RD) & ~force_ld;
  assign wr_go    = (acc_cmd == C_WR) & ~force_ld;
  assign wr_beat  = wr_need_q[0] | wr_go;

  always_comb begin
    opcode    = '0;
    opcode[5] = ld_sel;
    opcode[6] = ~ld_sel;
  end

  assign mem_cmd    = issue ? M_LOAD : {1'b0, acc_cmd};
  assign mem_addr   = issue ? opcode : acc_addr;
  assign mem_dq_oe  = issue | wr_beat;
  assign mem_dq_out = issue ? ld_data : (wr_beat ? acc_wdata : '0);
  assign mem_dqm    = rd_skp_q[2] | wr_skp_q[1] | (wr_go & acc_skip[1]);
  assign ld_ack     = issue;
  assign acc_stall  = force_ld;

  always_comb begin
    rd_need_n = rd_need_q >> 1;
    rd_skp_n  = rd_skp_q >> 1;
    wr_need_n = wr_need_q >> 1;
    wr_skp_n  = wr_skp_q >> 1;
    if (rd_go) begin
      for (int k = 0; k < BL; k++) begin
        rd_need_n[CL-1+k] = rd_need_n[CL-1+k] | ~acc_skip[k];
        rd_skp_n[CL-1+k]  = rd_skp_n[CL-1+k]  |  acc_skip[k];
      end
    end
    if (wr_go) begin
      for (int k = 1; k < BL; k++) begin
        wr_need_n[k-1] = wr_need_n[k-1] | ~acc_skip[k];
        wr_skp_n[k-1]  = wr_skp_n[k-1]  |  acc_skip[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_need_q <= '0;
      rd_skp_q  <= '0;
      wr_need_q <= '0;
      wr_skp_q  <= '0;
      wait_q    <= '0;
    end else begin
      rd_need_q <= rd_need_n;
      rd_skp_q  <= rd_skp_n;
      wr_need_q <= wr_need_n;
      wr_skp_q  <= wr_skp_n;
      if (!ld_req || issue)
        wait_q <= '0;
      else if (wait_q != TW'(TIMEOUT))
        wait_q <= wait_q + 1'b1;
    end
  end
endmodule

// File: rtl/smr_hide_sched_chk.sv
module smr_hide_sched_chk #(
  parameter int DW = 16,
  parameter int AW = 11,
  parameter int CL = 3,
  parameter int BL = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    acc_cmd,
  input logic [DW-1:0] acc_wdata,
  input logic          ld_req,
  input logic          ld_sel,
  input logic [DW-1:0] ld_data,
  input logic [2:0]    mem_cmd,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_dq_out,
  input logic          mem_dq_oe,
  input logic          mem_dqm,
  input logic          ld_ack,
  input logic          acc_stall
);
  localparam int PW = CL + BL - 1;

  logic [PW-1:0] pres, pres_n;
  logic          dqm1, dqm2;
  logic [AW-1:0] exp_op;

  always_comb begin
    exp_op    = '0;
    exp_op[5] = ld_sel;
    exp_op[6] = ~ld_sel;
    pres_n    = pres >> 1;
    if (mem_cmd == 3'd2)
      for (int k = 0; k < BL; k++) pres_n[CL-1+k] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pres <= '0;
      dqm1 <= 1'b0;
      dqm2 <= 1'b0;
    end else begin
      pres <= pres_n;
      dqm1 <= mem_dqm;
      dqm2 <= dqm1;
    end
  end

  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_req |-> (mem_cmd == {1'b0, acc_cmd}) && !acc_stall);
  p_opcode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == 3'd4) |-> (mem_addr == exp_op) && mem_dq_oe && (mem_dq_out == ld_data));
  p_hidden_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ack && !acc_stall) |-> (acc_cmd == 2'd0));
  p_beat0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == 3'd3) |-> mem_dq_oe && (mem_dq_out == acc_wdata));
  p_no_contention_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !(pres[0] && !dqm2));
  p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stall |-> ld_ack && (acc_cmd != 2'd0));
  p_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ack |-> ld_req && (mem_cmd == 3'd4));
endmodule

bind smr_hide_sched smr_hide_sched_chk #(.DW(DW), .AW(AW), .CL(CL), .BL(BL)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_cmd(acc_cmd), .acc_wdata(acc_wdata),
  .ld_req(ld_req), .ld_sel(ld_sel), .ld_data(ld_data),
  .mem_cmd(mem_cmd), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
  .mem_dq_oe(mem_dq_oe), .mem_dqm(mem_dqm), .ld_ack(ld_ack), .acc_stall(acc_stall)
);

// File: tb/test_smr_hide_sched.sv
module test_smr_hide_sched;
  localparam int DW = 16, AW = 11, CL = 3, BL = 8, TO = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic [1:0]    acc_cmd;
  logic [AW-1:0] acc_addr;
  logic [DW-1:0] acc_wdata;
  logic [BL-1:0] acc_skip;
  logic          ld_req, ld_sel;
  logic [DW-1:0] ld_data;
  logic [2:0]    mem_cmd;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_out;
  logic          mem_dq_oe, mem_dqm, ld_ack, acc_stall;

  smr_hide_sched #(.DW(DW), .AW(AW), .CL(CL), .BL(BL), .TIMEOUT(TO)) i_smr_hide_sched (
    .clk(clk), .rst_n(rst_n), .acc_cmd(acc_cmd), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_skip(acc_skip), .ld_req(ld_req), .ld_sel(ld_sel),
    .ld_data(ld_data), .mem_cmd(mem_cmd), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dqm(mem_dqm), .ld_ack(ld_ack), .acc_stall(acc_stall)
  );

  int nvec = 0, nerr = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] op_of(input logic s);
    op_of = s ? AW'(32) : AW'(64);
  endfunction

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic [1:0] c, input logic [AW-1:0] a, input logic [BL-1:0] s,
                       input logic [DW-1:0] w);
    acc_cmd = c; acc_addr = a; acc_skip = s; acc_wdata = w;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      drive(2'd0, '0, '0, '0);
      tick();
    end
  endtask

  // independent memory-side model: read data on DQ unless masked two cycles before
  int mc;
  bit pres[64];
  bit dqh[64];
  bit drv;
  always @(negedge clk) begin
    if (!rst_n) begin
      mc = 0;
      for (int i = 0; i < 64; i++) begin pres[i] = 0; dqh[i] = 0; end
    end else begin
      drv = pres[mc % 64] && !(mc >= 2 && dqh[(mc - 2) % 64]);
      chk(!(drv && mem_dq_oe), "R10", {31'd0, mem_dq_oe}, 32'd0);
      chk(ld_ack == (mem_cmd == 3'd4), "R12", {31'd0, ld_ack}, {31'd0, mem_cmd == 3'd4});
      if (mem_cmd == 3'd4)
        chk(mem_addr == op_of(ld_sel) && mem_dq_out == ld_data && mem_dq_oe, "R3",
            {5'd0, mem_addr, mem_dq_out}, {5'd0, op_of(ld_sel), ld_data});
      pres[mc % 64] = 0;
      dqh[mc % 64] = mem_dqm;
      if (mem_cmd == 3'd2)
        for (int k = 0; k < BL; k++) pres[(mc + CL + k) % 64] = 1;
      mc++;
    end
  end

  initial begin
    #2000000;
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    bit got;
    int ea;
    rst_n = 1'b0;
    drive(2'd0, '0, '0, '0);
    ld_req = 1'b0; ld_sel = 1'b0; ld_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(mem_cmd == 3'd0 && !mem_dq_oe && !mem_dqm && !ld_ack && !acc_stall, "R1",
        {27'd0, mem_cmd, mem_dq_oe, mem_dqm}, 32'd0);
    tick();

    for (int i = 0; i < 4; i++) begin
      drive(2'd1, AW'(i * 300 + 7), '0, '0);
      @(negedge clk);
      chk(mem_cmd == 3'd1 && mem_addr == AW'(i * 300 + 7) && !acc_stall, "R2",
          {18'd0, mem_cmd, mem_addr}, {18'd0, 3'd1, AW'(i * 300 + 7)});
      tick();
    end
    drive(2'd2, AW'(19), '0, '0);
    @(negedge clk);
    chk(mem_cmd == 3'd2 && mem_addr == AW'(19), "R2", {29'd0, mem_cmd}, 32'd2);
    tick();
    idle(12);

    for (int s = 0; s < 2; s++) begin
      ld_req = 1'b1; ld_sel = s[0]; ld_data = DW'(16'h5A00 + s);
      drive(2'd1, AW'(55), '0, '0);
      @(negedge clk);
      chk(!ld_ack && mem_cmd == 3'd1, "R5", {28'd0, ld_ack, mem_cmd}, 32'd1);
      tick();
      drive(2'd0, '0, '0, '0);
      @(negedge clk);
      chk(ld_ack && mem_cmd == 3'd4, "R5", {28'd0, ld_ack, mem_cmd}, 32'hC);
      chk(mem_addr == op_of(s[0]), "R3", {21'd0, mem_addr}, {21'd0, op_of(s[0])});
      tick();
      ld_req = 1'b0;
      idle(2);
    end

    ld_req = 1'b1; ld_sel = 1'b0; ld_data = 16'h6666;
    drive(2'd2, AW'(3), '0, '0);
    @(negedge clk);
    chk(!ld_ack && mem_cmd == 3'd2 && !mem_dq_oe, "R6", {31'd0, ld_ack}, 32'd0);
    tick();
    drive(2'd0, '0, '0, '0);
    @(negedge clk);
    chk(ld_ack, "R6", {31'd0, ld_ack}, 32'd1);
    tick();
    ld_req = 1'b0;
    idle(14);

    for (int k = 0; k <= BL; k++) begin
      ea = (k < BL) ? CL + k : CL + BL;
      ld_sel = k[0]; ld_data = DW'(16'h1000 + k);
      for (int t = 0; t <= CL + BL + 1; t++) begin
        if (t == 0) drive(2'd2, AW'(k), (k < BL) ? BL'(1 << k) : '0, '0);
        else drive(2'd0, '0, '0, '0);
        if (t == CL) ld_req = 1'b1;
        @(negedge clk);
        chk(mem_dqm == (k < BL && t == CL + k - 2), "R7", {31'd0, mem_dqm},
            {31'd0, k < BL && t == CL + k - 2});
        chk(ld_ack == (t == ea), "R4", {31'd0, ld_ack}, {31'd0, t == ea});
        got = ld_ack;
        tick();
        if (got) ld_req = 1'b0;
      end
      idle(2);
    end

    for (int k = 0; k < BL; k++) begin
      ea = (k == 0) ? BL : k;
      ld_sel = ~k[0]; ld_data = DW'(16'h2000 + k);
      for (int t = 0; t <= BL + 1; t++) begin
        if (t == 0) drive(2'd3, AW'(k), BL'(1 << k), 16'hC000);
        else drive(2'd0, '0, '0, DW'(16'hC000 + t));
        if (t == 1) ld_req = 1'b1;
        @(negedge clk);
        chk(mem_dqm == (k >= 1 && t == k - 1), "R8", {31'd0, mem_dqm}, {31'd0, k >= 1 && t == k - 1});
        chk(ld_ack == (t == ea), "R8", {31'd0, ld_ack}, {31'd0, t == ea});
        if (t == 0)
          chk(mem_dq_oe && mem_dq_out == 16'hC000 && mem_cmd == 3'd3, "R8",
              {15'd0, mem_dq_oe, mem_dq_out}, {15'd0, 1'b1, 16'hC000});
        else if (t < BL && t != ea)
          chk(mem_dq_oe && mem_dq_out == DW'(16'hC000 + t), "R9",
              {15'd0, mem_dq_oe, mem_dq_out}, {15'd0, 1'b1, DW'(16'hC000 + t)});
        else if (t >= BL && t != ea)
          chk(!mem_dq_oe, "R9", {31'd0, mem_dq_oe}, 32'd0);
        got = ld_ack;
        tick();
        if (got) ld_req = 1'b0;
      end
      idle(2);
    end

    ld_req = 1'b1; ld_sel = 1'b1; ld_data = 16'h7777;
    for (int t = 0; t <= TO + 1; t++) begin
      drive(2'd1, AW'(321), '0, '0);
      @(negedge clk);
      chk(acc_stall == (t == TO) && ld_ack == (t == TO), "R11", {30'd0, acc_stall, ld_ack},
          {30'd0, t == TO, t == TO});
      chk(mem_cmd == ((t == TO) ? 3'd4 : 3'd1), "R11", {29'd0, mem_cmd}, (t == TO) ? 32'd4 : 32'd1);
      if (t == TO + 1) chk(mem_addr == AW'(321), "R11", {21'd0, mem_addr}, 32'd321);
      got = ld_ack;
      tick();
      if (got) ld_req = 1'b0;
    end
    idle(2);

    ld_sel = 1'b0; ld_data = 16'h8888;
    for (int t = 0; t <= CL + BL + 1; t++) begin
      if (t == 0) drive(2'd2, AW'(9), '0, '0);
      else drive(2'd1, AW'(77), '0, '0);
      if (t == 1) ld_req = 1'b1;
      @(negedge clk);
      chk(ld_ack == (t == CL + BL) && acc_stall == (t == CL + BL), "R11",
          {30'd0, acc_stall, ld_ack}, {30'd0, t == CL + BL, t == CL + BL});
      got = ld_ack;
      tick();
      if (got) ld_req = 1'b0;
    end
    idle(3);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule